// File: doc/BRIEF.md
# CRC-Protected I2C Register Read Slave

This block is an I2C target that serves reads from a register space behind a simple synchronous read port. Every read is a framed exchange. The master first writes a header: a control byte, a high and a low address byte, an optional byte count, and a CRC-8 over the header. After a repeated start, the master addresses the slave for reading and clocks out either one data byte or a run of data bytes. A second CRC-8 follows the data and covers only the data bytes.

A flag in the high address byte selects single-byte or block mode. If the header CRC is wrong, the slave refuses the rest of the exchange until the bus goes idle. SCL and SDA arrive as plain inputs and are synchronised inside the block. SDA is driven open-drain through an output-enable, and the data driven is always low.

Top module: `i2c_crc_read_slave`

## Requirements
- R1: While reset is asserted, `sdaOe` and `regRdEn` are both low.
- R2: The slave acknowledges a control byte whose bits 7:1 equal `DEV_ADDR` and whose bit 0 is 0 (write). It also acknowledges every following header byte. A control byte carrying any other device address gets no acknowledge, and the slave stays silent until the next start.
- R3: The header CRC is CRC-8 with polynomial 0x07, initial value 0x00, processed MSB first. It runs over the write control byte, the high address byte and the low address byte in that order. The count byte is left out. When the received CRC byte matches, the slave acknowledges it.
- R4: When the header CRC does not match, that byte is not acknowledged. Until the next stop, a read control byte is not acknowledged and SDA is never driven. After a stop, the next exchange is served normally.
- R5: Bit 7 of the high address byte is the block flag: 0 selects single-byte mode and 1 selects block mode. The register address is {high[6:0], low[7:0]}. A count byte is expected only when the flag is 1.
- R6: In single-byte mode, the read phase returns the byte at the register address, then a payload CRC (same CRC-8) computed over that one byte.
- R7: In block mode, the read phase returns `count` bytes from consecutive addresses, wrapping modulo 2^15. A payload CRC computed over those data bytes only follows them.
- R8: A count byte of 0 in block mode returns exactly one data byte.
- R9: A read control byte (bits 7:1 = `DEV_ADDR`, bit 0 = 1) is acknowledged only when an accepted header precedes it in the same exchange. Otherwise it gets no acknowledge.
- R10: When the master does not acknowledge a data byte, the slave releases SDA and sends nothing more until the next start or stop.
- R11: Each data byte the slave prepares costs exactly one single-cycle `regRdEn` pulse with `regRdAddr` valid, and `regRdData` is taken on the following cycle. The next byte is fetched as the previous one finishes, so a complete read of n bytes makes n pulses.
- R12: `sdaOe` changes only while SCL is low, so the slave never forms a start or stop on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Sampled SCL line |
| sdaIn | input | 1 | Sampled SDA line |
| sdaOut | output | 1 | Level driven onto SDA when enabled (always 0) |
| sdaOe | output | 1 | SDA pull-down enable |
| regRdEn | output | 1 | Register read strobe |
| regRdAddr | output | 15 | Register address for the read strobe |
| regRdData | input | 8 | Register data, valid the cycle after the strobe |

## Verification
The bench targets three corner cases:

- **Count byte in the header CRC.** Block reads are checked against a CRC that leaves out the count byte. A design that folds the count byte into the CRC would NACK every block header.
- **Zero byte count.** A count of zero must still return one byte. Treating it literally would either send the payload CRC at once or underflow into a very long run.
- **Address wrap.** A read that starts just below the top of the address space must wrap. A design that gets this wrong returns bytes from the wrong addresses.

Corrupted headers are followed by a read attempt, which exposes a slave that keeps serving after a failed check. A master NACK in the middle of a block exposes a slave that keeps driving data onto the bus.

// File: rtl/crc_read_pkg.sv
package crc_read_pkg;
  localparam int BYTE_W     = 8;
  localparam int HDR_ADDR_W = 16;
  localparam int REG_ADDR_W = HDR_ADDR_W - 1;
  localparam int BIT_CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [BYTE_W-1:0] CRC_POLY = 8'h07;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_TXACK} busState_t;
  typedef enum logic [2:0] {P_CTRL, P_ADDRH, P_ADDRL, P_CNT, P_HCRC, P_DATA, P_PCRC, P_DONE} phase_t;
  typedef enum logic [1:0] {A_RX, A_TX, A_IDLE} ackNext_t;

  typedef struct packed {
    logic clrBits;
    logic rxShiftEn;
    logic txShiftEn;
    logic ackDrive;
    logic txDrive;
    logic captAddrH;
    logic captAddrL;
    logic captCnt;
    logic crcClr;
    logic crcInitRx;
    logic crcFeedRx;
    logic rdReq;
    logic cntDec;
    logic loadCrc;
  } ctlStb_t;

  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic sclLvl;
    logic sdaLvl;
    logic startDet;
    logic stopDet;
    logic byteFull;
    logic bitLast;
    logic blk;
    logic cntLast;
    logic hdrCrcOk;
    logic [BYTE_W-1:0] rxByte;
  } dpSts_t;

  function automatic logic [BYTE_W-1:0] crc8Step(input logic [BYTE_W-1:0] crcIn,
                                                 input logic [BYTE_W-1:0] d);
    logic [BYTE_W-1:0] c;
    c = crcIn;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      if (c[BYTE_W-1] ^ d[i]) c = (c << 1) ^ CRC_POLY;
      else                    c = c << 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/crc_read_dp.sv
module crc_read_dp
  import crc_read_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  ctlStb_t               stb,
  input  logic [BYTE_W-1:0]     regRdData,
  output dpSts_t                sts,
  output logic                  sdaOe,
  output logic [REG_ADDR_W-1:0] regRdAddr
);
  logic [SYNC_N-1:0] sclPipe, sdaPipe;
  logic sclQ, sdaQ, sclCur, sdaCur;
  logic [BYTE_W-1:0] rxShift, txShift, crc, cntRem;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic [REG_ADDR_W-1:0] addr;
  logic blk, rdPend;

  assign sclCur = sclPipe[SYNC_N-1];
  assign sdaCur = sdaPipe[SYNC_N-1];

  // two-stage (or deeper) synchronisers, idle bus reads high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_N-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_N-2:0], sdaIn};
      sclQ    <= sclCur;
      sdaQ    <= sdaCur;
    end
  end

  always_comb begin
    sts.sclRise  = sclCur & ~sclQ;
    sts.sclFall  = ~sclCur & sclQ;
    sts.sclLvl   = sclCur;
    sts.sdaLvl   = sdaCur;
    sts.startDet = sclCur & sclQ & sdaQ & ~sdaCur;
    sts.stopDet  = sclCur & sclQ & ~sdaQ & sdaCur;
    sts.byteFull = bitCnt == BIT_CNT_W'(BYTE_W);
    sts.bitLast  = bitCnt == BIT_CNT_W'(BYTE_W - 1);
    sts.blk      = blk;
    sts.cntLast  = cntRem == BYTE_W'(1);
    sts.hdrCrcOk = rxShift == crc;
    sts.rxByte   = rxShift;
  end

  // bit counter and shift registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
      txShift <= '1;
      rdPend  <= 1'b0;
    end else begin
      rdPend <= stb.rdReq;
      if (stb.clrBits) bitCnt <= '0;
      else if ((stb.rxShiftEn && sts.sclRise) || (stb.txShiftEn && sts.sclFall))
        bitCnt <= bitCnt + 1'b1;
      if (stb.rxShiftEn && sts.sclRise) rxShift <= {rxShift[BYTE_W-2:0], sdaCur};
      if (stb.loadCrc)                            txShift <= crc;
      else if (rdPend)                            txShift <= regRdData;
      else if (stb.txShiftEn && sts.sclFall)      txShift <= {txShift[BYTE_W-2:0], 1'b1};
    end
  end

  // shared CRC register: header first, payload after the read control byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               crc <= '0;
    else if (stb.crcClr)     crc <= '0;
    else if (stb.crcInitRx)  crc <= crc8Step('0, rxShift);
    else if (stb.crcFeedRx)  crc <= crc8Step(crc, rxShift);
    else if (rdPend)         crc <= crc8Step(crc, regRdData);
  end

  // address pointer, mode flag and remaining byte count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr   <= '0;
      blk    <= 1'b0;
      cntRem <= BYTE_W'(1);
    end else begin
      if (stb.captAddrH) begin
        blk                          <= rxShift[BYTE_W-1];
        addr[REG_ADDR_W-1:BYTE_W]    <= rxShift[REG_ADDR_W-BYTE_W-1:0];
      end
      if (stb.captAddrL) addr[BYTE_W-1:0] <= rxShift;
      if (stb.rdReq)     addr <= addr + 1'b1;
      if (stb.captAddrL)   cntRem <= BYTE_W'(1);
      else if (stb.captCnt) cntRem <= (rxShift == '0) ? BYTE_W'(1) : rxShift;
      else if (stb.cntDec)  cntRem <= cntRem - 1'b1;
    end
  end

  assign sdaOe     = stb.ackDrive | (stb.txDrive & ~txShift[BYTE_W-1]);
  assign regRdAddr = addr;
endmodule

// File: rtl/crc_read_ctl.sv
module crc_read_ctl
  import crc_read_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C
) (
  input  logic    clk,
  input  logic    rstN,
  input  dpSts_t  sts,
  output ctlStb_t stb
);
  busState_t state, stateN;
  phase_t    phase, phaseN;
  ackNext_t  ackNext, ackNextN;
  logic hdrValid, hdrValidN, lockout, lockoutN, mAck, mAckN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      phase    <= P_CTRL;
      ackNext  <= A_IDLE;
      hdrValid <= 1'b0;
      lockout  <= 1'b0;
      mAck     <= 1'b0;
    end else begin
      state    <= stateN;
      phase    <= phaseN;
      ackNext  <= ackNextN;
      hdrValid <= hdrValidN;
      lockout  <= lockoutN;
      mAck     <= mAckN;
    end
  end

  always_comb begin
    stb       = '0;
    stateN    = state;
    phaseN    = phase;
    ackNextN  = ackNext;
    hdrValidN = hdrValid;
    lockoutN  = lockout;
    mAckN     = mAck;
    stb.rxShiftEn = state == S_RX;
    stb.txShiftEn = state == S_TX;
    stb.ackDrive  = state == S_ACK;
    stb.txDrive   = state == S_TX;

    if (sts.stopDet) begin
      stateN    = S_IDLE;
      lockoutN  = 1'b0;
      hdrValidN = 1'b0;
    end else if (sts.startDet) begin
      if (lockout) stateN = S_IDLE;
      else begin
        stateN      = S_RX;
        phaseN      = P_CTRL;
        stb.clrBits = 1'b1;
      end
    end else begin
      case (state)
        S_RX: if (sts.sclFall && sts.byteFull) begin
          stateN   = S_ACK;
          ackNextN = A_RX;
          case (phase)
            P_CTRL: begin
              if (sts.rxByte[7:1] != DEV_ADDR) stateN = S_IDLE;
              else if (!sts.rxByte[0]) begin
                stb.crcInitRx = 1'b1;
                hdrValidN     = 1'b0;
                phaseN        = P_ADDRH;
              end else if (hdrValid) begin
                stb.crcClr = 1'b1;
                stb.rdReq  = 1'b1;
                hdrValidN  = 1'b0;
                phaseN     = P_DATA;
                ackNextN   = A_TX;
              end else stateN = S_IDLE;
            end
            P_ADDRH: begin
              stb.captAddrH = 1'b1;
              stb.crcFeedRx = 1'b1;
              phaseN        = P_ADDRL;
            end
            P_ADDRL: begin
              stb.captAddrL = 1'b1;
              stb.crcFeedRx = 1'b1;
              phaseN        = sts.blk ? P_CNT : P_HCRC;
            end
            P_CNT: begin
              stb.captCnt = 1'b1;
              phaseN      = P_HCRC;
            end
            P_HCRC: begin
              if (sts.hdrCrcOk) begin
                hdrValidN = 1'b1;
                ackNextN  = A_IDLE;
              end else begin
                lockoutN = 1'b1;
                stateN   = S_IDLE;
              end
            end
            default: stateN = S_IDLE;
          endcase
        end
        S_ACK: if (sts.sclFall) begin
          stb.clrBits = 1'b1;
          case (ackNext)
            A_RX:    stateN = S_RX;
            A_TX:    stateN = S_TX;
            default: stateN = S_IDLE;
          endcase
        end
        S_TX: if (sts.sclFall && sts.bitLast) begin
          stateN = S_TXACK;
          if (phase == P_DATA) begin
            if (sts.cntLast) begin
              stb.loadCrc = 1'b1;
              phaseN      = P_PCRC;
            end else begin
              stb.rdReq  = 1'b1;
              stb.cntDec = 1'b1;
            end
          end else phaseN = P_DONE;
        end
        S_TXACK: begin
          if (sts.sclRise) mAckN = ~sts.sdaLvl;
          if (sts.sclFall) begin
            stb.clrBits = 1'b1;
            stateN      = (mAck && phase != P_DONE) ? S_TX : S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_crc_read_slave.sv
module i2c_crc_read_slave
  import crc_read_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  parameter int         SYNC_N   = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOut,
  output logic                  sdaOe,
  output logic                  regRdEn,
  output logic [REG_ADDR_W-1:0] regRdAddr,
  input  logic [BYTE_W-1:0]     regRdData
);
  ctlStb_t stb;
  dpSts_t  sts;

  crc_read_dp #(.SYNC_N(SYNC_N)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .stb(stb),
    .regRdData(regRdData), .sts(sts), .sdaOe(sdaOe), .regRdAddr(regRdAddr)
  );

  crc_read_ctl #(.DEV_ADDR(DEV_ADDR)) u_ctl (
    .clk(clk), .rstN(rstN), .sts(sts), .stb(stb)
  );

  assign regRdEn = stb.rdReq;
  assign sdaOut  = 1'b0;
endmodule

// File: rtl/crc_read_chk.sv
module crc_read_chk
  import crc_read_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    sdaOe,
  input logic    regRdEn,
  input ctlStb_t stb,
  input dpSts_t  sts
);
  logic rstSeen;
  always_ff @(posedge clk) rstSeen <= !rstN;

  always_ff @(posedge clk) begin
    if (!rstN && rstSeen)
      a_r1_quiet_in_reset: assert (!sdaOe && !regRdEn)
        else $error("R1: outputs active during reset");
  end

  a_r12_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    (sts.sclLvl && $past(sts.sclLvl)) |-> $stable(sdaOe));

  a_r11_single_cycle_fetch: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> !regRdEn);

  a_r7_no_count_underrun: assert property (@(posedge clk) disable iff (!rstN)
    stb.cntDec |-> !sts.cntLast);

  a_r5_count_only_in_block: assert property (@(posedge clk) disable iff (!rstN)
    stb.captCnt |-> sts.blk);
endmodule

bind i2c_crc_read_slave crc_read_chk u_chk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .regRdEn(regRdEn), .stb(stb), .sts(sts)
);

// File: tb/i2c_crc_read_slave_bench.sv
module i2c_crc_read_slave_bench;
  localparam logic [6:0] DEV = 7'h2C;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaOut, sdaOe, regRdEn;
  logic [14:0] regRdAddr;
  logic [7:0] regRdData = 8'h00;
  logic sdaBus;
  int vecs = 0, miss = 0, rdPulses = 0, r12Bad = 0;
  logic prevScl = 1'b1, prevOe = 1'b0;

  always #2.5 clk = ~clk;
  assign sdaBus = sdaM & (sdaOe ? sdaOut : 1'b1);

  i2c_crc_read_slave #(.DEV_ADDR(DEV)) u_i2c_crc_read_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOut(sdaOut),
    .sdaOe(sdaOe), .regRdEn(regRdEn), .regRdAddr(regRdAddr), .regRdData(regRdData)
  );

  function automatic logic [7:0] memByte(input logic [14:0] a);
    logic [15:0] t;
    t = {1'b0, a} * 16'd29;
    return t[7:0] ^ t[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) r = (r[7] ^ d[i]) ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  always_ff @(posedge clk) if (regRdEn) regRdData <= memByte(regRdAddr);
  always @(posedge clk) if (regRdEn) rdPulses <= rdPulses + 1;

  // R12 monitor: sdaOe must hold while SCL stays high
  always @(negedge clk) begin
    if (rstN && sclM && prevScl && (sdaOe != prevOe)) r12Bad <= r12Bad + 1;
    prevScl <= sclM;
    prevOe  <= sdaOe;
  end

  task automatic check(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart;
    sdaM = 1'b0; waitQ(Q); sclM = 1'b0; waitQ(Q);
  endtask

  task automatic busRestart;
    sdaM = 1'b1; waitQ(Q); sclM = 1'b1; waitQ(Q); sdaM = 1'b0; waitQ(Q); sclM = 1'b0; waitQ(Q);
  endtask

  task automatic busStop;
    sdaM = 1'b0; waitQ(Q); sclM = 1'b1; waitQ(Q); sdaM = 1'b1; waitQ(2 * Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitQ(Q); sclM = 1'b1; waitQ(Q); sclM = 1'b0; waitQ(Q);
    end
    sdaM = 1'b1; waitQ(Q); sclM = 1'b1; waitQ(Q / 2);
    acked = !sdaBus;
    waitQ(Q / 2); sclM = 1'b0; waitQ(Q);
  endtask

  task automatic recvByte(input logic masterAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ(Q); sclM = 1'b1; waitQ(Q / 2); b[i] = sdaBus; waitQ(Q / 2); sclM = 1'b0;
    end
    sdaM = !masterAck; waitQ(Q); sclM = 1'b1; waitQ(Q); sclM = 1'b0; waitQ(Q); sdaM = 1'b1;
  endtask

  task automatic readTxn(input logic [14:0] addr, input logic blk, input logic [7:0] cnt,
                         input logic corrupt, input logic nackFirst);
    logic [7:0] ctlW, ah, al, hc, pc, got, expB;
    logic ack;
    int n, p0;
    string tag;
    ctlW = {DEV, 1'b0};
    ah   = {blk, addr[14:8]};
    al   = addr[7:0];
    hc   = crc8(crc8(crc8(8'h00, ctlW), ah), al);  // R3: count byte excluded
    if (corrupt) hc = hc ^ 8'h21;
    n   = !blk ? 1 : ((cnt == 8'd0) ? 1 : int'(cnt));
    tag = !blk ? "R6" : ((cnt == 8'd0) ? "R8" : "R7");
    p0  = rdPulses;
    busStart;
    sendByte(ctlW, ack); check("R2 ctrl ack", int'(ack), 1);
    sendByte(ah, ack);   check("R2 addr-hi ack", int'(ack), 1);
    sendByte(al, ack);   check("R2 addr-lo ack", int'(ack), 1);
    if (blk) begin sendByte(cnt, ack); check("R5 count ack", int'(ack), 1); end
    sendByte(hc, ack);
    check(corrupt ? "R4 bad crc nack" : "R3 crc ack", int'(ack), int'(!corrupt));
    busRestart;
    sendByte({DEV, 1'b1}, ack);
    check(corrupt ? "R4 read refused" : "R9 read accepted", int'(ack), int'(!corrupt));
    if (corrupt) begin
      recvByte(1'b0, got); check("R4 silent", int'(got), 8'hFF);
      busStop;
      return;
    end
    pc = 8'h00;
    for (int i = 0; i < n; i++) begin
      recvByte(!(nackFirst && i == 0), got);
      expB = memByte(addr + 15'(i));
      check({tag, " R5 data"}, int'(got), int'(expB));
      pc = crc8(pc, expB);
      if (nackFirst) begin
        recvByte(1'b0, got); check("R10 released", int'(got), 8'hFF);
        busStop;
        return;
      end
    end
    recvByte(1'b0, got); check({tag, " payload crc"}, int'(got), int'(pc));
    busStop;
    check("R11 fetch count", rdPulses - p0, n);
  endtask

  task automatic runAll;
    logic ack;
    logic [7:0] got;
    // R1: quiet during and right after reset
    waitQ(10);
    check("R1 oe in reset", int'(sdaOe), 0);
    check("R1 rd in reset", int'(regRdEn), 0);
    rstN = 1'b1;
    waitQ(10);
    check("R1 oe after reset", int'(sdaOe), 0);
    // R2: foreign device address ignored
    busStart;
    sendByte({DEV ^ 7'h11, 1'b0}, ack); check("R2 foreign nack", int'(ack), 0);
    sendByte(8'h00, ack);               check("R2 stays silent", int'(ack), 0);
    busStop;
    // R9: read without a header
    busStart;
    sendByte({DEV, 1'b1}, ack); check("R9 no header nack", int'(ack), 0);
    recvByte(1'b0, got);        check("R9 no data", int'(got), 8'hFF);
    busStop;
    readTxn(15'h1234, 1'b0, 8'd0, 1'b0, 1'b0);   // R6
    readTxn(15'h0100, 1'b1, 8'd4, 1'b0, 1'b0);   // R7
    readTxn(15'h2A55, 1'b1, 8'd0, 1'b0, 1'b0);   // R8
    readTxn(15'h7FFE, 1'b1, 8'd3, 1'b0, 1'b0);   // R7 wrap
    readTxn(15'h0042, 1'b0, 8'd0, 1'b1, 1'b0);   // R4
    readTxn(15'h0042, 1'b0, 8'd0, 1'b0, 1'b0);   // R4 recovery
    readTxn(15'h0777, 1'b1, 8'd5, 1'b1, 1'b0);   // R4 block
    readTxn(15'h0300, 1'b1, 8'd3, 1'b0, 1'b1);   // R10
    for (int k = 0; k < 14; k++) begin
      logic [14:0] a;
      logic b, c;
      logic [7:0] cn;
      a  = 15'($urandom);
      b  = 1'($urandom);
      cn = 8'($urandom % 6);
      c  = ($urandom % 5) == 0;
      readTxn(a, b, cn, c, 1'b0);
    end
    check("R12 sda steady while scl high", r12Bad, 0);
  endtask

  initial begin
    bit timedOut;
    timedOut = 1'b0;
    void'($urandom(32'd20240611));
    fork
      runAll;
      begin repeat (190000) @(posedge clk); timedOut = 1'b1; end
    join_any
    disable fork;
    if (timedOut) begin
      vecs++;
      miss++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule